// File: doc/BRIEF.md
# Keyboard Command Responder

This block plays the keyboard end of a serial keyboard link. A host sends it command bytes; some commands make it discard whatever is waiting and queue a short fixed reply. Key events arrive as raw codes, and bit 7 of each code marks a release. The block translates the lower seven bits through a parameterised lookup map. A prefix byte selects a second map for the next event only. The two lock keys pass through a toggle filter, so that a keyboard with toggle-lock keys reports one make and one break for each full on/off cycle.

All output bytes go into a byte FIFO. The host sees the head byte and a data-available flag, and pops the head with a read strobe. A command and a key event may arrive in the same clock cycle. One cycle can therefore push up to four bytes, flush the FIFO and pop it, all at once. Line signalling and baud timing are left to the surrounding logic.

Top module: `kbd_responder`

## Requirements
- R1: After reset the FIFO is empty, `data_avail` is 0 and `rd_data` reads 0x00.
- R2: An accepted command 0x01 empties the FIFO and then queues the three bytes 0xFF, 0x04, 0x7F, in that order.
- R3: An accepted command 0x07 or 0x0F empties the FIFO and then queues 0xFE followed by 0x00.
- R4: An accepted command 0x0E queues nothing and causes the next accepted command byte, whatever its value, to be swallowed with no effect. Any other command value has no effect.
- R5: A command byte is accepted only while `tx_en` is 1 and `port_off` is 0. A command byte that is not accepted has no effect and does not use up a pending 0x0E skip.
- R6: A key event with code c (not 0xE0, not filtered) pushes NORM[c & 0x7F] | (c & 0x80). The default map is NORM[i] = (37*i + 11) mod 128.
- R7: Key code 0xE0 pushes nothing and arms the extended mode. The next pushed key event uses EXT[i] instead of NORM and clears the mode. The default map is EXT[i] = (13*i + 5) mod 128 for odd i and 0 for even i. A key event that is filtered away leaves the mode armed.
- R8: Each lock key (press codes 58 and 69; release codes 186 and 197) keeps a 2-bit state. A press flips bit 0 and a release flips bit 1. A press is dropped when the new state is 2, and a release is dropped when the new state is 3.
- R9: The FIFO holds 256 bytes in arrival order. A byte that arrives when the FIFO is full is dropped.
- R10: With the FIFO empty, `rd_data` is 0x00 and a read strobe changes nothing. Otherwise a strobe removes the head byte at the clock edge.
- R11: Within one cycle, command reply bytes are queued ahead of a key event's byte. A read strobe in the same cycle as a flush is absorbed by the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte from the host |
| tx_en | input | 1 | Host transmitter enabled; commands are accepted only when 1 |
| port_off | input | 1 | Port disabled; commands are ignored when 1 |
| key_valid | input | 1 | Raw key event strobe |
| key_code | input | 8 | Raw key code, bit 7 = release |
| rd_en | input | 1 | Pop the FIFO head |
| rd_data | output | 8 | FIFO head byte, 0x00 when empty |
| data_avail | output | 1 | FIFO holds at least one byte |

## Verification
The hardest state to reach is a full FIFO combined with other events. Dropping a byte on overflow needs 256 queued bytes, so the stimulus streams a long run of key events with no reads, keeps going past the limit, and then drains the FIFO and compares every byte. A second difficult corner is a single cycle that carries a reset command, a key event and a read strobe together. It is driven directly, while the FIFO holds stale bytes, so that flush order, push order and pop absorption are all tested at once. The lock filter needs its full four-event cycle repeated, and the sequences also place a lock event between an 0xE0 prefix and its key.

// File: rtl/kbdr_pkg.sv
package kbdr_pkg;

  typedef logic [127:0][6:0] kmap_t;

  localparam int REPLY_MAX = 3;
  localparam int PUSH_MAX  = REPLY_MAX + 1;

  localparam logic [7:0] OP_RESET  = 8'h01;
  localparam logic [7:0] OP_LAYOUT = 8'h07;
  localparam logic [7:0] OP_LAYALT = 8'h0F;
  localparam logic [7:0] OP_LEDS   = 8'h0E;
  localparam logic [7:0] KEY_EXTPF = 8'hE0;

  function automatic kmap_t build_norm_map();
    kmap_t m;
    for (int i = 0; i < 128; i++) m[i] = 7'((i * 37 + 11) % 128);
    return m;
  endfunction

  function automatic kmap_t build_ext_map();
    kmap_t m;
    for (int i = 0; i < 128; i++) m[i] = (i % 2 == 1) ? 7'((i * 13 + 5) % 128) : 7'd0;
    return m;
  endfunction

  function automatic logic [7:0] key_translate(kmap_t m, logic [7:0] raw);
    return {raw[7], m[raw[6:0]]};
  endfunction

endpackage

// File: rtl/kbdr_cmd.sv
module kbdr_cmd
  import kbdr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [7:0]                  cmd_byte,
  input  logic                        tx_en,
  input  logic                        port_off,
  output logic                        flush,
  output logic [1:0]                  reply_n,
  output logic [REPLY_MAX-1:0][7:0]   reply_bytes
);

  logic cmd_take;
  logic led_armed, led_next;

  assign cmd_take = cmd_valid && tx_en && !port_off;

  always_comb begin
    flush       = 1'b0;
    reply_n     = 2'd0;
    reply_bytes = '0;
    led_next    = led_armed;
    if (cmd_take) begin
      if (led_armed) begin
        led_next = 1'b0;
      end else begin
        case (cmd_byte)
          OP_RESET: begin
            flush          = 1'b1;
            reply_n        = 2'd3;
            reply_bytes[0] = 8'hFF;
            reply_bytes[1] = 8'h04;
            reply_bytes[2] = 8'h7F;
          end
          OP_LAYOUT, OP_LAYALT: begin
            flush          = 1'b1;
            reply_n        = 2'd2;
            reply_bytes[0] = 8'hFE;
            reply_bytes[1] = 8'h00;
          end
          OP_LEDS: led_next = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_armed <= 1'b0;
    else        led_armed <= led_next;
  end

  AST_CMD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (!tx_en || port_off)) |=> ($stable(led_armed))); // R5
  AST_LED_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && tx_en && !port_off && led_armed) |-> (!flush && reply_n == 2'd0)); // R4
  AST_LED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && tx_en && !port_off && led_armed) |=> !led_armed); // R4

endmodule

// File: rtl/kbdr_keyx.sv
module kbdr_keyx
  import kbdr_pkg::*;
#(
  parameter kmap_t NORM_MAP = build_norm_map(),
  parameter kmap_t EXT_MAP  = build_ext_map(),
  parameter int    NLOCK    = 2,
  parameter logic [NLOCK-1:0][6:0] LOCK_KEYS = {7'd69, 7'd58}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [7:0] key_code,
  output logic       key_push,
  output logic [7:0] key_out
);

  logic             ext_mode;
  logic             is_prefix;
  logic [1:0]       lock_st  [NLOCK];
  logic [1:0]       lock_nxt [NLOCK];
  logic [NLOCK-1:0] lock_drop;
  logic             key_drop;

  assign is_prefix = key_valid && (key_code == KEY_EXTPF);

  always_comb begin
    for (int j = 0; j < NLOCK; j++) begin
      logic hp, hr;
      hp = key_valid && (key_code == {1'b0, LOCK_KEYS[j]});
      hr = key_valid && (key_code == {1'b1, LOCK_KEYS[j]});
      lock_nxt[j]  = lock_st[j] ^ {hr, hp};
      lock_drop[j] = (hp && lock_nxt[j] == 2'b10) || (hr && lock_nxt[j] == 2'b11);
    end
  end

  assign key_drop = |lock_drop;
  assign key_push = key_valid && !is_prefix && !key_drop;
  assign key_out  = ext_mode ? key_translate(EXT_MAP, key_code)
                             : key_translate(NORM_MAP, key_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_mode <= 1'b0;
      for (int j = 0; j < NLOCK; j++) lock_st[j] <= 2'b00;
    end else begin
      if (is_prefix)     ext_mode <= 1'b1;
      else if (key_push) ext_mode <= 1'b0;
      for (int j = 0; j < NLOCK; j++) lock_st[j] <= lock_nxt[j];
    end
  end

  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    is_prefix |-> !key_push); // R7
  AST_EXT_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (key_push && !is_prefix) |=> !ext_mode); // R7
  AST_RELEASE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    key_push |-> (key_out[7] == key_code[7])); // R6
  AST_ONE_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_drop)); // R8

endmodule

// File: rtl/kbdr_fifo.sv
module kbdr_fifo #(
  parameter int DEPTH = 256,
  parameter int MAXP  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  pop_req,
  input  logic [$clog2(MAXP+1)-1:0] push_n,
  input  logic [MAXP-1:0][7:0]  push_data,
  output logic [7:0]            rd_data,
  output logic                  avail
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int NW = $clog2(MAXP + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr, base_w, rptr_n;
  logic [CW-1:0] count, base_cnt, space;
  logic [NW-1:0] acc;
  logic          pop_ok, push_drop;

  assign pop_ok = pop_req && (count != '0);
  assign avail  = (count != '0);
  assign rd_data = avail ? mem[rptr] : 8'h00;

  always_comb begin
    base_cnt  = flush ? '0 : (count - CW'(pop_ok));
    base_w    = flush ? '0 : wptr;
    rptr_n    = flush ? '0 : (rptr + AW'(pop_ok));
    space     = CW'(DEPTH) - base_cnt;
    acc       = (CW'(push_n) > space) ? NW'(space) : push_n;
    push_drop = (acc != push_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wptr  <= '0;
      rptr  <= '0;
    end else begin
      count <= base_cnt + CW'(acc);
      wptr  <= base_w + AW'(acc);
      rptr  <= rptr_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAXP; k++) begin
      if (NW'(k) < acc) mem[base_w + AW'(k)] <= push_data[k];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !pop_req && !flush && push_n != '0) |-> push_drop); // R9
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && avail && !flush && push_n == '0) |=> (count == $past(count) - 1'b1)); // R10
  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && !flush && push_n == '0) |=> !avail); // R10

endmodule

// File: rtl/kbd_responder.sv
module kbd_responder
  import kbdr_pkg::*;
#(
  parameter int    DEPTH    = 256,
  parameter kmap_t NORM_MAP = build_norm_map(),
  parameter kmap_t EXT_MAP  = build_ext_map()
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       tx_en,
  input  logic       port_off,
  input  logic       key_valid,
  input  logic [7:0] key_code,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       data_avail
);

  localparam int NW = $clog2(PUSH_MAX + 1);

  logic                      flush;
  logic [1:0]                reply_n;
  logic [REPLY_MAX-1:0][7:0] reply_bytes;
  logic                      key_push;
  logic [7:0]                key_out;
  logic [NW-1:0]             push_n;
  logic [PUSH_MAX-1:0][7:0]  push_data;

  kbdr_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .tx_en(tx_en), .port_off(port_off), .flush(flush),
    .reply_n(reply_n), .reply_bytes(reply_bytes)
  );

  kbdr_keyx #(.NORM_MAP(NORM_MAP), .EXT_MAP(EXT_MAP)) u_keyx (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .key_push(key_push), .key_out(key_out)
  );

  always_comb begin
    push_n = NW'(reply_n) + NW'(key_push);
    for (int k = 0; k < PUSH_MAX; k++) begin
      if (k < REPLY_MAX && NW'(k) < NW'(reply_n)) push_data[k] = reply_bytes[k % REPLY_MAX];
      else if (NW'(k) == NW'(reply_n))            push_data[k] = key_out;
      else                                        push_data[k] = 8'h00;
    end
  end

  kbdr_fifo #(.DEPTH(DEPTH), .MAXP(PUSH_MAX)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pop_req(rd_en),
    .push_n(push_n), .push_data(push_data),
    .rd_data(rd_data), .avail(data_avail)
  );

  AST_KEY_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (key_push && reply_n != 2'd0) |-> (push_data[reply_n] == key_out)); // R11
  AST_FLUSH_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> data_avail); // R2

endmodule

// File: tb/kbd_responder_test.sv
module kbd_responder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       tx_en = 1'b1;
  logic       port_off = 1'b0;
  logic       key_valid = 1'b0;
  logic [7:0] key_code = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       data_avail;

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 0;

  byte unsigned mq[$];
  int  lk58 = 0, lk69 = 0;
  bit  m_ext = 0, m_led = 0;

  always #5 clk = ~clk;

  kbd_responder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .tx_en(tx_en), .port_off(port_off), .key_valid(key_valid),
    .key_code(key_code), .rd_en(rd_en), .rd_data(rd_data), .data_avail(data_avail)
  );

  function automatic int nmap(int i);
    return (i * 37 + 11) % 128;
  endfunction
  function automatic int emap(int i);
    if (i % 2 == 0) return 0;
    return (i * 13 + 5) % 128;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    byte unsigned add[$];
    bit fl;
    fl = 0;
    add = {};
    if (!rst_n) begin
      mq = {}; lk58 = 0; lk69 = 0; m_ext = 0; m_led = 0;
    end else begin
      if (cmd_valid && tx_en && !port_off) begin
        if (m_led) m_led = 0;
        else if (cmd_byte == 8'h01) begin fl = 1; add = {8'hFF, 8'h04, 8'h7F}; end
        else if (cmd_byte == 8'h07 || cmd_byte == 8'h0F) begin fl = 1; add = {8'hFE, 8'h00}; end
        else if (cmd_byte == 8'h0E) m_led = 1;
      end
      if (key_valid) begin
        bit drop;
        int c;
        c = key_code;
        drop = 0;
        if (c == 58)       begin lk58 ^= 1; drop = (lk58 == 2); end
        else if (c == 69)  begin lk69 ^= 1; drop = (lk69 == 2); end
        else if (c == 186) begin lk58 ^= 2; drop = (lk58 == 3); end
        else if (c == 197) begin lk69 ^= 2; drop = (lk69 == 3); end
        else if (c == 'hE0) begin m_ext = 1; drop = 1; end
        if (!drop) begin
          int v;
          v = m_ext ? emap(c % 128) : nmap(c % 128);
          m_ext = 0;
          add.push_back(byte'(v + (c / 128) * 128));
        end
      end
      if (fl) mq = {};
      else if (rd_en && mq.size() > 0) void'(mq.pop_front());
      foreach (add[i]) if (mq.size() < 256) mq.push_back(add[i]);
    end
  end

  task automatic compare();
    logic [7:0] ed;
    logic ea;
    ed = (mq.size() > 0) ? mq[0] : 8'h00;
    ea = (mq.size() > 0);
    checks++;
    if (rd_data !== ed || data_avail !== ea) begin
      errors++;
      $display("FAIL %s: rd_data=%02h data_avail=%b expected %02h %b", tag, rd_data, data_avail, ed, ea);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
    cmd_valid = 0; key_valid = 0; rd_en = 0;
  endtask

  task automatic key(input logic [7:0] c);
    key_valid = 1; key_code = c; cyc();
  endtask
  task automatic cmd(input logic [7:0] c);
    cmd_valid = 1; cmd_byte = c; cyc();
  endtask
  task automatic drain();
    for (int i = 0; i < 300 && mq.size() > 0; i++) begin rd_en = 1; cyc(); end
    cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1;
    cyc();
    tag = "R1"; rd_en = 1; cyc();

    tag = "R6";
    key(8'h05); key(8'h85); key(8'h7F); key(8'h00); key(8'hFF);
    drain();

    tag = "R7";
    key(8'hE0); key(8'h1C); key(8'h1C);
    key(8'hE0); key(8'h9D); key(8'hE0); key(8'h22);
    drain();

    tag = "R8";
    for (int r = 0; r < 2; r++) begin
      key(8'd58); key(8'd186); key(8'd58); key(8'd186);
    end
    key(8'd69); key(8'd197); key(8'd69); key(8'd197);
    key(8'hE0); key(8'd186); key(8'd58); key(8'h33);
    drain();

    tag = "R2";
    key(8'h10); key(8'h11);
    cmd(8'h01); cyc();
    drain();

    tag = "R3";
    key(8'h12); cmd(8'h07); drain();
    key(8'h13); cmd(8'h0F); drain();

    tag = "R4";
    key(8'h14);
    cmd(8'h0E); cmd(8'h01); cmd(8'h55); cmd(8'h01); cmd(8'h0E); cmd(8'h0E); cmd(8'h07);
    drain();

    tag = "R5";
    key(8'h15);
    tx_en = 0; cmd(8'h01); tx_en = 1;
    port_off = 1; cmd(8'h07); cmd(8'h0E); port_off = 0;
    cmd(8'h0E); tx_en = 0; cmd(8'h01); tx_en = 1; cmd(8'h07); cmd(8'h07);
    drain();

    tag = "R9";
    for (int i = 0; i < 300; i++) begin
      key_valid = 1; key_code = 8'((i % 50) + 1); cyc();
    end
    drain();

    tag = "R10";
    rd_en = 1; cyc(); rd_en = 1; cyc();
    key(8'h21); rd_en = 1; cyc(); rd_en = 1; cyc();

    tag = "R11";
    key(8'h30); key(8'h31);
    cmd_valid = 1; cmd_byte = 8'h01; key_valid = 1; key_code = 8'h40; rd_en = 1; cyc();
    drain();
    cmd_valid = 1; cmd_byte = 8'h0F; key_valid = 1; key_code = 8'hC1; cyc();
    drain();

    finish_run();
  end

endmodule